// File: doc/BRIEF.md
# Mailbox Receive FIFO

This block is the receive side of an inter-processor mailbox. Remote senders push 64-bit messages into a circular FIFO. Each message carries the number of the channel it came from. A local core works through a 32-bit register port. It reads the oldest entry as a low word, a high word and a channel number, and it removes that entry by writing a trigger register.

Software gets the raw read pointer, the raw write pointer and a full flag in one status word, plus the configured depth. From these it works out how many entries are waiting, including the case where the two pointers are equal. A level-style pending bit follows the non-empty state and can be cleared by writing one to it. A mask bit gates the pending bit onto the interrupt line. Writing zero to the flush register returns the FIFO to its empty state.

Top module: `mbx_rx_fifo`

## Requirements
- R1: After reset, the status word reads 0, the pending register reads 0, the mask register reads 0x1F, and both `irq` and `push_full` are low.
- R2: Reads of offset 0x04, 0x08 and 0x00 return the oldest entry's low word, high word and channel number (zero-extended). Entries come out in the order they were pushed.
- R3: A push while the FIFO holds DEPTH entries is rejected. `push_full` is high during such a push, and neither the pointers nor the stored entries change.
- R4: Writing a value with bit 0 set to offset 0x0C removes the oldest entry. A write with bit 0 clear does nothing, and a removal request while the FIFO is empty is ignored.
- R5: The status word at 0x14 holds the read pointer in bits 31:24, the write pointer in bits 23:16 and the full flag in bit 2, with all other bits zero. Each pointer steps by one and wraps from DEPTH-1 to 0.
- R6: When the pointers are equal, the FIFO holds DEPTH entries if bit 2 is set and none otherwise. When they differ, the occupancy is (write - read) modulo DEPTH.
- R7: Offset 0x24 reads DEPTH-1.
- R8: Bit 0 at 0x18 becomes 1 one cycle after the FIFO is non-empty. Writing 1 to bit 0 at 0x18 clears it. If entries remain, it is set again on the following cycle.
- R9: Offset 0x1C holds a 5-bit mask that reads back as written. `irq` is high exactly when the pending bit is 1 and mask bit 0 is 0.
- R10: Writing 0 to offset 0x10 empties the FIFO: both pointers, the full flag and the pending bit are cleared, and the mask is kept. Writing a non-zero value to 0x10 has no effect. A flush takes priority over a push or removal in the same cycle.
- R11: A push and a removal in the same cycle, with the FIFO neither empty nor full, both take effect and leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Sender offers a message this cycle |
| push_lo | input | 32 | Low word of the offered message |
| push_hi | input | 32 | High word of the offered message |
| push_id | input | ID_W | Channel number of the offered message |
| push_full | output | 1 | FIFO is full; a push in this cycle is rejected |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Not-empty interrupt |

## Verification
The bench targets the point where the pointers meet. A design that dropped the full flag would report a full FIFO as empty. A design that accepted a push while full would overwrite the oldest message.

It also drives removal requests on an empty FIFO and simultaneous push/removal pairs at both occupancy limits. Wrong handling of either shows up as a drifting read pointer or a lost entry.

The pending bit is probed on the cycle of a clear and on the cycle after it, to catch a design that never sets it again. Flush is tried with both zero and non-zero data, which catches a design that resets on any write.

// File: rtl/mbx_rx_fifo.sv
module mbx_rx_fifo #(
  parameter int DEPTH = 8,
  parameter int ID_W  = 3,
  parameter int AW    = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_valid,
  input  logic [31:0]     push_lo,
  input  logic [31:0]     push_hi,
  input  logic [ID_W-1:0] push_id,
  output logic            push_full,
  input  logic            reg_wen,
  input  logic [AW-1:0]   reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            irq
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] A_ID   = AW'(8'h00);
  localparam logic [AW-1:0] A_LO   = AW'(8'h04);
  localparam logic [AW-1:0] A_HI   = AW'(8'h08);
  localparam logic [AW-1:0] A_POP  = AW'(8'h0C);
  localparam logic [AW-1:0] A_RST  = AW'(8'h10);
  localparam logic [AW-1:0] A_STS  = AW'(8'h14);
  localparam logic [AW-1:0] A_PEND = AW'(8'h18);
  localparam logic [AW-1:0] A_MASK = AW'(8'h1C);
  localparam logic [AW-1:0] A_DEP  = AW'(8'h24);
  localparam logic [PW-1:0] LAST   = PW'(DEPTH - 1);

  logic [31:0]     mem_lo [DEPTH];
  logic [31:0]     mem_hi [DEPTH];
  logic [ID_W-1:0] mem_id [DEPTH];

  logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic          full_q, pend_q;
  logic [4:0]    mask_q;
  logic          empty, do_push, do_pop, flush, pend_clr;

  assign wr_nxt   = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
  assign rd_nxt   = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
  assign empty    = (wr_ptr == rd_ptr) && !full_q;
  assign flush    = reg_wen && reg_addr == A_RST && reg_wdata == 32'd0;
  assign pend_clr = reg_wen && reg_addr == A_PEND && reg_wdata[0];
  assign do_push  = push_valid && !full_q && !flush;
  assign do_pop   = reg_wen && reg_addr == A_POP && reg_wdata[0] && !empty;
  assign push_full = full_q;
  assign irq       = pend_q && !mask_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      full_q <= 1'b0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      full_q <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= wr_nxt;
      if (do_pop)  rd_ptr <= rd_nxt;
      if (do_push && !do_pop && wr_nxt == rd_ptr) full_q <= 1'b1;
      else if (do_pop && !do_push)                full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      mem_lo[wr_ptr] <= push_lo;
      mem_hi[wr_ptr] <= push_hi;
      mem_id[wr_ptr] <= push_id;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pend_q <= 1'b0;
    else if (flush || pend_clr) pend_q <= 1'b0;
    else if (!empty)           pend_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  mask_q <= 5'h1F;
    else if (reg_wen && reg_addr == A_MASK)      mask_q <= reg_wdata[4:0];
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_ID:    reg_rdata = 32'(mem_id[rd_ptr]);
      A_LO:    reg_rdata = mem_lo[rd_ptr];
      A_HI:    reg_rdata = mem_hi[rd_ptr];
      A_STS:   reg_rdata = {8'(rd_ptr), 8'(wr_ptr), 13'd0, full_q, 2'b00};
      A_PEND:  reg_rdata = {31'd0, pend_q};
      A_MASK:  reg_rdata = {27'd0, mask_q};
      A_DEP:   reg_rdata = 32'(DEPTH - 1);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mbx_rx_fifo_chk.sv
module mbx_rx_fifo_chk #(
  parameter int DEPTH = 8,
  parameter int PW    = 3,
  parameter int AW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_valid,
  input logic          push_full,
  input logic          irq,
  input logic          reg_wen,
  input logic [AW-1:0] reg_addr,
  input logic [31:0]   reg_wdata,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] rd_ptr,
  input logic          full_q,
  input logic          pend_q,
  input logic          mask0
);
  logic pop_wr, flush_wr;
  assign pop_wr   = reg_wen && reg_addr == AW'(8'h0C) && reg_wdata[0];
  assign flush_wr = reg_wen && reg_addr == AW'(8'h10) && reg_wdata == 32'd0;

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_full && !pop_wr && !flush_wr) |=> ($stable(wr_ptr) && full_q));

  p_pop_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_wr && wr_ptr == rd_ptr && !full_q && !push_valid) |=> $stable(rd_ptr));

  p_ptr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(wr_ptr) < DEPTH) && (int'(rd_ptr) < DEPTH));

  p_full_eq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> (wr_ptr == rd_ptr));

  p_pend_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(wr_ptr != rd_ptr || full_q));

  p_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mask0 |-> !irq);

  p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_wr |=> (wr_ptr == '0 && rd_ptr == '0 && !full_q && !pend_q));
endmodule

bind mbx_rx_fifo mbx_rx_fifo_chk #(.DEPTH(DEPTH), .PW(PW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_full(push_full),
  .irq(irq), .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .full_q(full_q), .pend_q(pend_q),
  .mask0(mask_q[0])
);

// File: tb/mbx_rx_fifo_tb.sv
`timescale 1ns/1ps
module mbx_rx_fifo_tb;
  localparam int DEPTH = 8;
  localparam int ID_W  = 3;
  localparam int AW    = 6;

  logic clk = 0, rst_n = 0;
  logic push_valid = 0, push_full, reg_wen = 0, irq;
  logic [31:0] push_lo = 0, push_hi = 0, reg_wdata = 0, reg_rdata;
  logic [ID_W-1:0] push_id = 0;
  logic [AW-1:0] reg_addr = 0;

  always #10 clk = ~clk;

  mbx_rx_fifo #(.DEPTH(DEPTH), .ID_W(ID_W), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_lo(push_lo),
    .push_hi(push_hi), .push_id(push_id), .push_full(push_full),
    .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  int n_run = 0, n_fail = 0;
  logic [31:0] q_lo [DEPTH];
  logic [31:0] q_hi [DEPTH];
  logic [31:0] q_id [DEPTH];
  int m_wr = 0, m_rd = 0;
  bit m_full = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status();
    return {8'(m_rd), 8'(m_wr), 13'd0, m_full, 2'b00};
  endfunction

  function automatic int m_count();
    if (m_full) return DEPTH;
    return (m_wr - m_rd + DEPTH) % DEPTH;
  endfunction

  function automatic int occ_from(logic [31:0] s);
    int w = int'(s[23:16]);
    int r = int'(s[31:24]);
    if (w == r) return s[2] ? DEPTH : 0;
    return (w - r + DEPTH) % DEPTH;
  endfunction

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    reg_wen = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 0; reg_wdata = 0;
  endtask

  task automatic step_op(bit dp, bit dpop, logic [31:0] lo, logic [31:0] hi, logic [31:0] id);
    bit pe, po;
    push_valid = dp; push_lo = lo; push_hi = hi; push_id = id[ID_W-1:0];
    if (dpop) begin reg_wen = 1; reg_addr = AW'(8'h0C); reg_wdata = 32'h1; end
    #1;
    if (dp) chk("R3 push_full", {31'd0, push_full}, {31'd0, m_full});
    @(negedge clk);
    push_valid = 0; reg_wen = 0; reg_wdata = 0;
    pe = dp && !m_full;
    po = dpop && !(m_wr == m_rd && !m_full);
    if (pe) begin q_lo[m_wr] = lo; q_hi[m_wr] = hi; q_id[m_wr] = id & 32'h7; end
    if (pe && !po && ((m_wr + 1) % DEPTH) == m_rd) m_full = 1;
    else if (po && !pe) m_full = 0;
    if (pe) m_wr = (m_wr + 1) % DEPTH;
    if (po) m_rd = (m_rd + 1) % DEPTH;
  endtask

  task automatic check_state(string tag);
    logic [31:0] d;
    rd(AW'(8'h14), d);
    chk({"R5 status ", tag}, d, exp_status());
    chk({"R6 occupancy ", tag}, 32'(occ_from(d)), 32'(m_count()));
    if (m_count() != 0) begin
      rd(AW'(8'h04), d); chk({"R2 head lo ", tag}, d, q_lo[m_rd]);
      rd(AW'(8'h08), d); chk({"R2 head hi ", tag}, d, q_hi[m_rd]);
      rd(AW'(8'h00), d); chk({"R2 head id ", tag}, d, q_id[m_rd]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    rd(AW'(8'h14), d); chk("R1 status", d, 32'd0);
    rd(AW'(8'h18), d); chk("R1 pending", d, 32'd0);
    rd(AW'(8'h1C), d); chk("R1 mask", d, 32'h1F);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 push_full", {31'd0, push_full}, 32'd0);
    rd(AW'(8'h24), d); chk("R7 depth", d, 32'(DEPTH - 1));

    for (int i = 0; i < DEPTH; i++) begin
      step_op(1, 0, 32'hA000_0000 + i, 32'hB000_0000 + i, i);
      check_state("fill");
    end
    chk("R3 full flag", {31'd0, push_full}, 32'd1);
    step_op(1, 0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 5);
    check_state("reject");
    rd(AW'(8'h14), d);
    chk("R6 equal ptrs full", {31'd0, d[31:24] == d[23:16] && d[2]}, 32'd1);

    rd(AW'(8'h18), d); chk("R8 pending set", d, 32'd1);
    chk("R9 masked irq", {31'd0, irq}, 32'd0);
    wr(AW'(8'h1C), 32'h1E);
    rd(AW'(8'h1C), d); chk("R9 mask readback", d, 32'h1E);
    chk("R9 irq unmasked", {31'd0, irq}, 32'd1);
    wr(AW'(8'h1C), 32'hFFFF_FFFF);
    rd(AW'(8'h1C), d); chk("R9 mask width", d, 32'h1F);
    chk("R9 irq masked again", {31'd0, irq}, 32'd0);
    wr(AW'(8'h1C), 32'h0);

    wr(AW'(8'h18), 32'h1);
    rd(AW'(8'h18), d); chk("R8 cleared", d, 32'd0);
    chk("R9 irq follows clear", {31'd0, irq}, 32'd0);
    @(negedge clk);
    rd(AW'(8'h18), d); chk("R8 reasserted", d, 32'd1);

    wr(AW'(8'h0C), 32'h2);
    check_state("R4 bit0 clear no pop");
    for (int i = 0; i < DEPTH; i++) begin
      step_op(0, 1, 0, 0, 0);
      check_state("drain");
    end
    step_op(0, 1, 0, 0, 0);
    check_state("R4 empty pop");
    chk("R4 empty status", exp_status(), {8'(m_rd), 8'(m_wr), 24'd0});
    wr(AW'(8'h18), 32'h1);
    @(negedge clk);
    rd(AW'(8'h18), d); chk("R8 stays clear when empty", d, 32'd0);
    chk("R9 irq low empty", {31'd0, irq}, 32'd0);

    step_op(1, 0, 32'h1111, 32'h2222, 3);
    step_op(1, 1, 32'h3333, 32'h4444, 4);
    check_state("R11 push+pop");
    chk("R11 occupancy", 32'(m_count()), 32'd1);
    step_op(0, 1, 0, 0, 0);
    step_op(1, 1, 32'h5555, 32'h6666, 6);
    check_state("R11 empty push+pop");

    step_op(1, 0, 32'h7777, 32'h8888, 1);
    wr(AW'(8'h10), 32'h5);
    check_state("R10 nonzero write");
    wr(AW'(8'h10), 32'h0);
    m_wr = 0; m_rd = 0; m_full = 0;
    @(negedge clk);
    rd(AW'(8'h14), d); chk("R10 flush status", d, 32'd0);
    rd(AW'(8'h18), d); chk("R10 flush pending", d, 32'd0);
    rd(AW'(8'h1C), d); chk("R10 mask kept", d, 32'd0);

    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom % 100);
      bit dp = (r < 45) || (r >= 85);
      bit dpop = (r >= 45);
      step_op(dp, dpop, $urandom, $urandom, $urandom % 8);
      check_state("random R5");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule